// File: doc/BRIEF.md
# Sentinel-Framed Serial Byte Transmitter

This block sends one byte at a time over an asynchronous serial line. Each frame has one low start bit, eight data bits sent least significant bit first, and one high stop bit. All logic runs on a single system clock. Bit timing comes from a one-cycle baud-tick enable supplied from outside the block. A rising edge on the request input starts a frame. That edge is detected on the system clock, so a request pulse of any width, even one cycle, produces exactly one frame.

The block does not use a bit counter. A 10-bit frame register shifts right with zero fill. When the register holds only a one in its lowest bit, it is empty. The serial line is bit 0 of this register, so the retained stop bit holds the line high between frames. The busy flag is the XOR of two toggle flags. One flips when a request is accepted. The other flips when a frame that was in progress returns to the empty pattern. Busy therefore spans the whole time from the request until the frame has finished.

Top module: `sentinel_uart_tx`

## Requirements
- R1: While reset is high, the block goes to idle on each clock. After reset, the line is high and busy is low, even if reset was applied in the middle of a frame.
- R2: Busy goes high on the first clock edge at which the request is sampled high after being sampled low, provided busy was low before that edge.
- R3: A frame is loaded only on a baud-tick cycle while a request is pending and the register is empty. Until that tick the line stays high and busy stays high. The data byte is sampled on the load tick only.
- R4: Starting with the load tick, the line shows in turn: the start bit 0, then data bits 0 through 7, then the stop bit 1. Each value is held from one baud tick to the next, and the line changes only on the edge that ends a baud-tick cycle.
- R5: Busy stays high through the load tick and the nine ticks after it. It falls on the tenth baud tick after the load tick, and the line stays high from then on.
- R6: One request edge produces exactly one frame. A request held high past the end of its frame starts no further frame.
- R7: A request edge seen while busy is high is ignored and is not queued. No frame follows the current one.
- R8: Baud ticks with no request pending leave the line high and busy low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | One-cycle enable marking each bit period |
| req | input | 1 | Send request; its rising edge starts one frame |
| data_in | input | 8 | Byte to send, sampled on the load tick |
| tx_line | output | 1 | Serial output, idles high |
| busy | output | 1 | High from an accepted request until its frame ends |

## Verification
On every cycle, the assertions check the following:
- the idle state after reset;
- that busy rises after an accepted request edge;
- that the line moves only on baud-tick edges;
- that a falling line or falling busy happens only at a tick;
- that the line is high whenever busy is low.

Only the directed scenarios can show the bit order of each frame, that busy lasts exactly ten ticks, that data is sampled at the load tick and not at the request, and that held or repeated requests give no second frame. These are checked for bytes with alternating, all-zero and all-one bits, and for tick spacings from back-to-back up to several idle cycles.

// File: rtl/sentinel_tx_pkg.sv
package sentinel_tx_pkg;

    localparam int DEF_DATA_W = 8;

    // Per-cycle control decisions for the frame register.
    typedef struct packed {
        logic load;
        logic shift;
    } shift_ctl_t;

    // Empty marker: a one in bit 0 and zeros above it.
    function automatic logic [DEF_DATA_W+1:0] empty_pattern();
        logic [DEF_DATA_W+1:0] p;
        p = '0;
        p[0] = 1'b1;
        return p;
    endfunction

endpackage

// File: rtl/req_edge_capture.sv
module req_edge_capture (
    input  logic clk,
    input  logic rst,
    input  logic req,
    input  logic block,
    output logic req_toggle
);
    logic req_q;
    logic rise;

    assign rise = req & ~req_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q      <= 1'b0;
            req_toggle <= 1'b0;
        end else begin
            req_q <= req;
            if (rise && !block) begin
                req_toggle <= ~req_toggle;
            end
        end
    end
endmodule

// File: rtl/frame_shifter.sv
module frame_shifter
    import sentinel_tx_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              baud_tick,
    input  logic              start_pending,
    input  logic [DATA_W-1:0] data_in,
    output logic              line_out,
    output logic              is_empty,
    output logic              load_now
);
    localparam int FRAME_W = DATA_W + 2;
    localparam logic [FRAME_W-1:0] EMPTY = {{(FRAME_W-1){1'b0}}, 1'b1};

    logic [FRAME_W-1:0] frame_q;
    shift_ctl_t         ctl;

    assign is_empty = (frame_q == EMPTY);

    always_comb begin
        ctl.load  = baud_tick & start_pending & is_empty;
        ctl.shift = baud_tick & ~is_empty;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_q <= EMPTY;
        end else if (ctl.load) begin
            frame_q <= {1'b1, data_in, 1'b0};
        end else if (ctl.shift) begin
            frame_q <= {1'b0, frame_q[FRAME_W-1:1]};
        end
    end

    assign line_out = frame_q[0];
    assign load_now = ctl.load;
endmodule

// File: rtl/busy_tracker.sv
module busy_tracker (
    input  logic clk,
    input  logic rst,
    input  logic baud_tick,
    input  logic is_empty,
    input  logic load_now,
    input  logic req_toggle,
    output logic busy,
    output logic start_pending
);
    logic in_flight;
    logic done_toggle;
    logic finish;

    assign finish        = baud_tick & in_flight & is_empty;
    assign busy          = req_toggle ^ done_toggle;
    assign start_pending = busy & ~in_flight;

    always_ff @(posedge clk) begin
        if (rst) begin
            in_flight   <= 1'b0;
            done_toggle <= 1'b0;
        end else begin
            if (load_now) begin
                in_flight <= 1'b1;
            end else if (finish) begin
                in_flight <= 1'b0;
            end
            if (finish) begin
                done_toggle <= ~done_toggle;
            end
        end
    end
endmodule

// File: rtl/sentinel_uart_tx.sv
module sentinel_uart_tx
    import sentinel_tx_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              baud_tick,
    input  logic              req,
    input  logic [DATA_W-1:0] data_in,
    output logic              tx_line,
    output logic              busy
);
    logic req_toggle;
    logic start_pending;
    logic is_empty;
    logic load_now;

    req_edge_capture u_edge (
        .clk        (clk),
        .rst        (rst),
        .req        (req),
        .block      (busy),
        .req_toggle (req_toggle)
    );

    frame_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk           (clk),
        .rst           (rst),
        .baud_tick     (baud_tick),
        .start_pending (start_pending),
        .data_in       (data_in),
        .line_out      (tx_line),
        .is_empty      (is_empty),
        .load_now      (load_now)
    );

    busy_tracker u_busy (
        .clk           (clk),
        .rst           (rst),
        .baud_tick     (baud_tick),
        .is_empty      (is_empty),
        .load_now      (load_now),
        .req_toggle    (req_toggle),
        .busy          (busy),
        .start_pending (start_pending)
    );
endmodule

// File: rtl/sentinel_uart_tx_checker.sv
module sentinel_uart_tx_checker (
    input logic clk,
    input logic rst,
    input logic baud_tick,
    input logic req,
    input logic tx_line,
    input logic busy
);
    // R1: one cycle in reset leaves the outputs idle
    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (tx_line && !busy));

    // R2: an accepted rising request edge raises busy
    a_r2_busy_rise: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !busy && req && !$past(req)) |=> busy);

    // R3: the line only falls (start bit) at a tick while busy
    a_r3_start_on_tick: assert property (@(posedge clk) disable iff (rst)
        ($fell(tx_line) && !$past(rst)) |-> ($past(baud_tick) && $past(busy)));

    // R4: the line holds still across cycles without a tick
    a_r4_hold_between_ticks: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(baud_tick)) |-> $stable(tx_line));

    // R5: busy ends only on a tick edge
    a_r5_busy_falls_on_tick: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy) && !$past(rst)) |-> $past(baud_tick));

    // R8: an idle block keeps the line high
    a_r8_idle_high: assert property (@(posedge clk) disable iff (rst)
        !busy |-> tx_line);
endmodule

bind sentinel_uart_tx sentinel_uart_tx_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .baud_tick (baud_tick),
    .req       (req),
    .tx_line   (tx_line),
    .busy      (busy)
);

// File: tb/sentinel_uart_tx_bench.sv
`timescale 1ns/1ps
module sentinel_uart_tx_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       baud_tick = 1'b0;
    logic       req = 1'b0;
    logic [7:0] data_in = 8'h00;
    logic       tx_line;
    logic       busy;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    sentinel_uart_tx u_sentinel_uart_tx (
        .clk       (clk),
        .rst       (rst),
        .baud_tick (baud_tick),
        .req       (req),
        .data_in   (data_in),
        .tx_line   (tx_line),
        .busy      (busy)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
        end
    endtask

    // One clock with the given tick value; inputs change at negedge.
    task automatic step(input logic tick);
        baud_tick = tick;
        @(posedge clk);
        @(negedge clk);
        baud_tick = 1'b0;
    endtask

    function automatic logic frame_bit(input logic [7:0] d, input int b);
        if (b == 0) return 1'b0;
        if (b == 9) return 1'b1;
        return d[b-1];
    endfunction

    // Drive ticks from the load tick through completion and check every bit.
    task automatic drain(input logic [7:0] d, input int gap, input bit poke_mid);
        logic prev = 1'b1;
        for (int b = 0; b < 10; b++) begin
            for (int g = 0; g < gap; g++) begin
                step(1'b0);
                check("R4 hold", tx_line, prev);
            end
            if (poke_mid && b == 5) begin
                req = 1'b1; step(1'b0);
                req = 1'b0; step(1'b0);
                check("R7 busy", busy, 1'b1);
                check("R4 hold", tx_line, prev);
            end
            step(1'b1);
            if (b == 0) data_in = ~d;
            prev = frame_bit(d, b);
            check("R4 bit", tx_line, prev);
            check("R5 busy", busy, 1'b1);
        end
        for (int g = 0; g < gap; g++) step(1'b0);
        step(1'b1);
        check("R5 end", busy, 1'b0);
        check("R5 line", tx_line, 1'b1);
    endtask

    task automatic run_frame(input logic [7:0] d, input int gap, input bit hold,
                             input bit poke_mid);
        data_in = d;
        req = 1'b1;
        step(1'b0);
        if (!hold) req = 1'b0;
        check("R2 busy", busy, 1'b1);
        check("R3 wait", tx_line, 1'b1);
        drain(d, gap, poke_mid);
        for (int k = 0; k < 3; k++) begin
            step(1'b1);
            if (hold) begin
                check("R6 busy", busy, 1'b0);
                check("R6 line", tx_line, 1'b1);
            end else if (poke_mid) begin
                check("R7 busy", busy, 1'b0);
                check("R7 line", tx_line, 1'b1);
            end else begin
                check("R8 busy", busy, 1'b0);
            end
        end
        req = 1'b0;
        step(1'b0);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        step(1'b0); step(1'b0);
        rst = 1'b0;
        check("R1 line", tx_line, 1'b1);
        check("R1 busy", busy, 1'b0);
    endtask

    task automatic t_idle_ticks;
        for (int k = 0; k < 5; k++) begin
            step(1'b1);
            check("R8 line", tx_line, 1'b1);
            check("R8 busy", busy, 1'b0);
        end
    endtask

    task automatic t_pending;
        data_in = 8'hC3;
        req = 1'b1; step(1'b0);
        req = 1'b0;
        for (int k = 0; k < 4; k++) begin
            step(1'b0);
            check("R3 pend busy", busy, 1'b1);
            check("R3 pend line", tx_line, 1'b1);
        end
        data_in = 8'h3C;
        drain(8'h3C, 1, 1'b0);
        step(1'b0);
    endtask

    task automatic t_reset_mid;
        data_in = 8'h00;
        req = 1'b1; step(1'b0);
        req = 1'b0;
        step(1'b1); step(1'b1); step(1'b1);
        rst = 1'b1; step(1'b0);
        rst = 1'b0;
        check("R1 mid line", tx_line, 1'b1);
        check("R1 mid busy", busy, 1'b0);
        step(1'b1);
        check("R1 after tick", tx_line, 1'b1);
        check("R1 after busy", busy, 1'b0);
    endtask

    initial begin
        @(negedge clk);
        t_reset;
        t_idle_ticks;
        run_frame(8'hA5, 2, 1'b0, 1'b0);
        run_frame(8'h00, 0, 1'b0, 1'b0);
        run_frame(8'hFF, 1, 1'b0, 1'b0);
        t_pending;
        run_frame(8'h5A, 1, 1'b1, 1'b0);
        run_frame(8'h96, 2, 1'b0, 1'b1);
        t_reset_mid;
        run_frame(8'h81, 3, 1'b0, 1'b0);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            vectors++;
            miscompares++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule